// File: doc/BRIEF.md
# Blocking Direct-Mapped Write-Back Data Cache

This block is a single-level data cache that sits between a processor request port and a slower, line-wide memory port. It holds 1024 lines of four 32-bit words. Each line has a tag, a valid flag and a modified (dirty) flag. Writes follow a write-back, write-allocate policy: a store only updates the cache, and memory sees the line only when that line is evicted.

The processor raises a request with an address, a read/write flag and store data, then stalls until the block pulses `cpu_ready`. A binary-encoded state machine first latches the request and checks the tag.
- On a hit, the access completes in the following cycle.
- On a miss to a modified line, the whole 128-bit victim line is first written to memory through a multi-cycle request/ready handshake.
- The missing line is then fetched through the same handshake, and the machine goes back to the tag check, so that every access finishes as a hit.

Top module: `dm_wb_cache`

## Requirements
- R1: After reset `cpu_ready` and `mem_req` are low and every line is invalid, so the first access to any address misses. A reset issued while a line is modified discards that line without any memory write.
- R2: The address fields are laid out as follows:
  - tag: bits 31:14
  - line index: bits 13:4
  - word within the line: bits 3:2 (word 0 in line bits 31:0, word 3 in bits 127:96)

  Addresses that differ only in the tag share one line. Every memory address has bits 3:0 equal to zero.
- R3: A read hit returns the selected word on `cpu_rdata`. `cpu_ready` is seen two cycles after the request is raised.
- R4: A read miss to an invalid or clean line issues exactly one memory read, at {request tag, index, 4'b0000}, with no memory write. The access then completes as a hit, LAT+4 cycles after the request is raised, where LAT is the memory latency in cycles.
- R5: A write miss fetches the line before merging the store word. The other three words keep their memory values, and the line becomes modified.
- R6: A write hit changes only the selected word, marks the line modified and causes no memory traffic.
- R7: A miss to a modified line first writes the full 128-bit victim line to {stored tag, index, 4'b0000}. It then fetches the new line and completes 2*LAT+5 cycles after the request is raised. Data written back is returned by later reads.
- R8: A miss to a clean line performs no memory write.
- R9: `cpu_ready` is a single-cycle pulse and is never high while a memory request is outstanding. Only one access is in progress at a time.
- R10: `mem_req`, `mem_write` and `mem_addr` stay stable from the raising of a memory request until its `mem_ready` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ready` |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request outstanding |
| mem_write | output | 1 | 1 = line write, 0 = line read |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_wdata | output | 128 | Victim line for write-back |
| mem_rdata | input | 128 | Fetched line, valid with `mem_ready` |
| mem_ready | input | 1 | One-cycle completion of a memory access |

## Verification
The bench targets conflict misses between two tags that share an index:
- If a design skips the write-back of a modified victim, a stored word reads back as the stale memory value.
- If a design writes back a clean line, its memory write count rises where it should stay put.
- If a design places the victim at the new tag, the write-back address reveals it.

Write misses are checked for preserving the untouched words and for leaving the line modified. A design that forgot to merge the store, or to set the dirty flag, either returns memory data or loses the store on the next eviction. The top and bottom indexes are exercised, a reset is applied over a modified line, and the exact hit, clean-miss and dirty-miss latencies are measured, so a lost or extra state shows as a cycle count mismatch.

// File: rtl/cache_pkg.sv
package cache_pkg;

   // Controller states, binary encoded
   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_COMPARE = 2'd1,
      ST_WRBACK  = 2'd2,
      ST_FILL    = 2'd3
   } cache_state_t;

   localparam int unsigned DEF_ADDR_W = 32;
   localparam int unsigned DEF_WORD_W = 32;
   localparam int unsigned DEF_WORDS  = 4;
   localparam int unsigned DEF_LINES  = 1024;

endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
   parameter int unsigned LINES = 1024,
   parameter int unsigned TAG_W = 18,
   parameter int unsigned IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   output logic [TAG_W-1:0] tag_out,
   output logic             valid_out,
   output logic             dirty_out,
   input  logic             fill_en,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic             dirty_set
);

   logic [LINES-1:0] valid_q;
   logic [LINES-1:0] dirty_q;
   logic [TAG_W-1:0] tag_mem [LINES];

   // Flags are flops so that reset invalidates every line at once
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else if (fill_en) begin
         valid_q[idx] <= 1'b1;
         dirty_q[idx] <= 1'b0;
      end else if (dirty_set) begin
         dirty_q[idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en) begin
         tag_mem[idx] <= fill_tag;
      end
   end

   assign tag_out   = tag_mem[idx];
   assign valid_out = valid_q[idx];
   assign dirty_out = dirty_q[idx];

endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
   parameter int unsigned LINES  = 1024,
   parameter int unsigned WORD_W = 32,
   parameter int unsigned WORDS  = 4,
   parameter int unsigned IDX_W  = $clog2(LINES),
   parameter int unsigned SEL_W  = $clog2(WORDS),
   parameter int unsigned LINE_W = WORD_W * WORDS
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  idx,
   output logic [LINE_W-1:0] line_out,
   input  logic              fill_en,
   input  logic [LINE_W-1:0] fill_line,
   input  logic              word_en,
   input  logic [SEL_W-1:0]  word_sel,
   input  logic [WORD_W-1:0] word_data
);

   // One storage lane per word so a store touches a single lane
   for (genvar w = 0; w < WORDS; w++) begin : g_lane
      logic [WORD_W-1:0] lane_mem [LINES];

      always_ff @(posedge clk) begin
         if (fill_en) begin
            lane_mem[idx] <= fill_line[w*WORD_W +: WORD_W];
         end else if (word_en && (word_sel == SEL_W'(w))) begin
            lane_mem[idx] <= word_data;
         end
      end

      assign line_out[w*WORD_W +: WORD_W] = lane_mem[idx];
   end

endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
   import cache_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned WORD_W = 32,
   parameter int unsigned WORDS  = 4,
   parameter int unsigned IDX_W  = 10,
   parameter int unsigned OFF_W  = 4,
   parameter int unsigned SEL_W  = 2,
   parameter int unsigned TAG_W  = ADDR_W - IDX_W - OFF_W,
   parameter int unsigned LINE_W = WORD_W * WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   // processor side
   input  logic              cpu_valid,
   input  logic              cpu_write,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [WORD_W-1:0] cpu_wdata,
   output logic [WORD_W-1:0] cpu_rdata,
   output logic              cpu_ready,
   // memory side
   output logic              mem_req,
   output logic              mem_write,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [LINE_W-1:0] mem_wdata,
   input  logic [LINE_W-1:0] mem_rdata,
   input  logic              mem_ready,
   // storage side
   output logic [IDX_W-1:0]  idx,
   input  logic [TAG_W-1:0]  tag_in,
   input  logic              valid_in,
   input  logic              dirty_in,
   input  logic [LINE_W-1:0] line_in,
   output logic              fill_en,
   output logic [TAG_W-1:0]  fill_tag,
   output logic [LINE_W-1:0] fill_line,
   output logic              dirty_set,
   output logic              word_en,
   output logic [SEL_W-1:0]  word_sel,
   output logic [WORD_W-1:0] word_data
);

   localparam int unsigned BYTE_W = OFF_W - SEL_W;
   localparam int unsigned REQ_W  = ADDR_W - BYTE_W;

   cache_state_t      state_q, state_d;
   logic [REQ_W-1:0]  req_addr_q;
   logic              req_wr_q;
   logic [WORD_W-1:0] req_wdata_q;
   logic [WORD_W-1:0] rdata_q;
   logic              ready_q;
   logic [TAG_W-1:0]  req_tag;
   logic              hit;
   logic              unused_byte_bits;

   assign unused_byte_bits = ^cpu_addr[BYTE_W-1:0];

   assign req_tag  = req_addr_q[REQ_W-1 -: TAG_W];
   assign idx      = req_addr_q[OFF_W-BYTE_W +: IDX_W];
   assign word_sel = req_addr_q[0 +: SEL_W];
   assign hit      = valid_in && (tag_in == req_tag);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:    if (cpu_valid && !ready_q) state_d = ST_COMPARE;
         ST_COMPARE: begin
            if (hit)           state_d = ST_IDLE;
            else if (dirty_in) state_d = ST_WRBACK;
            else               state_d = ST_FILL;
         end
         ST_WRBACK:  if (mem_ready) state_d = ST_FILL;
         ST_FILL:    if (mem_ready) state_d = ST_COMPARE;
         default:    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         req_addr_q  <= '0;
         req_wr_q    <= 1'b0;
         req_wdata_q <= '0;
         rdata_q     <= '0;
         ready_q     <= 1'b0;
      end else begin
         state_q <= state_d;
         ready_q <= (state_q == ST_COMPARE) && hit;
         if ((state_q == ST_IDLE) && cpu_valid && !ready_q) begin
            req_addr_q  <= cpu_addr[ADDR_W-1:BYTE_W];
            req_wr_q    <= cpu_write;
            req_wdata_q <= cpu_wdata;
         end
         if ((state_q == ST_COMPARE) && hit && !req_wr_q) begin
            rdata_q <= line_in[word_sel*WORD_W +: WORD_W];
         end
      end
   end

   // Memory side is a function of the state and the latched request
   assign mem_req   = (state_q == ST_WRBACK) || (state_q == ST_FILL);
   assign mem_write = (state_q == ST_WRBACK);
   assign mem_addr  = (state_q == ST_WRBACK) ? {tag_in, idx, {OFF_W{1'b0}}}
                                             : {req_tag, idx, {OFF_W{1'b0}}};
   assign mem_wdata = line_in;

   assign fill_en   = (state_q == ST_FILL) && mem_ready;
   assign fill_tag  = req_tag;
   assign fill_line = mem_rdata;
   assign word_en   = (state_q == ST_COMPARE) && hit && req_wr_q;
   assign dirty_set = word_en;
   assign word_data = req_wdata_q;

   assign cpu_ready = ready_q;
   assign cpu_rdata = rdata_q;

endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache
   import cache_pkg::*;
#(
   parameter int unsigned ADDR_W = DEF_ADDR_W,
   parameter int unsigned WORD_W = DEF_WORD_W,
   parameter int unsigned WORDS  = DEF_WORDS,
   parameter int unsigned LINES  = DEF_LINES
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cpu_valid,
   input  logic                      cpu_write,
   input  logic [ADDR_W-1:0]         cpu_addr,
   input  logic [WORD_W-1:0]         cpu_wdata,
   output logic [WORD_W-1:0]         cpu_rdata,
   output logic                      cpu_ready,
   output logic                      mem_req,
   output logic                      mem_write,
   output logic [ADDR_W-1:0]         mem_addr,
   output logic [WORD_W*WORDS-1:0]   mem_wdata,
   input  logic [WORD_W*WORDS-1:0]   mem_rdata,
   input  logic                      mem_ready
);

   localparam int unsigned LINE_W = WORD_W * WORDS;
   localparam int unsigned OFF_W  = $clog2(LINE_W / 8);
   localparam int unsigned IDX_W  = $clog2(LINES);
   localparam int unsigned SEL_W  = $clog2(WORDS);
   localparam int unsigned TAG_W  = ADDR_W - IDX_W - OFF_W;

   logic [IDX_W-1:0]  idx;
   logic [TAG_W-1:0]  tag_rd;
   logic              valid_rd;
   logic              dirty_rd;
   logic [LINE_W-1:0] line_rd;
   logic              fill_en;
   logic [TAG_W-1:0]  fill_tag;
   logic [LINE_W-1:0] fill_line;
   logic              dirty_set;
   logic              word_en;
   logic [SEL_W-1:0]  word_sel;
   logic [WORD_W-1:0] word_data;

   cache_ctrl #(
      .ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS), .IDX_W(IDX_W),
      .OFF_W(OFF_W), .SEL_W(SEL_W), .TAG_W(TAG_W), .LINE_W(LINE_W)
   ) i_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
      .mem_req(mem_req), .mem_write(mem_write), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
      .idx(idx), .tag_in(tag_rd), .valid_in(valid_rd), .dirty_in(dirty_rd),
      .line_in(line_rd), .fill_en(fill_en), .fill_tag(fill_tag),
      .fill_line(fill_line), .dirty_set(dirty_set), .word_en(word_en),
      .word_sel(word_sel), .word_data(word_data)
   );

   cache_tag_store #(
      .LINES(LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)
   ) i_tags (
      .clk(clk), .rst_n(rst_n), .idx(idx),
      .tag_out(tag_rd), .valid_out(valid_rd), .dirty_out(dirty_rd),
      .fill_en(fill_en), .fill_tag(fill_tag), .dirty_set(dirty_set)
   );

   cache_data_store #(
      .LINES(LINES), .WORD_W(WORD_W), .WORDS(WORDS),
      .IDX_W(IDX_W), .SEL_W(SEL_W), .LINE_W(LINE_W)
   ) i_data (
      .clk(clk), .idx(idx), .line_out(line_rd),
      .fill_en(fill_en), .fill_line(fill_line),
      .word_en(word_en), .word_sel(word_sel), .word_data(word_data)
   );

endmodule

// File: rtl/dm_wb_cache_chk.sv
module dm_wb_cache_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned WORD_W = 32,
   parameter int unsigned WORDS  = 4,
   parameter int unsigned LINES  = 1024
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_ready,
   input logic              mem_req,
   input logic              mem_write,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ready
);

   localparam int unsigned OFF_W = $clog2(WORD_W * WORDS / 8);

   initial begin
      AST_PARAM_LINES: assert (LINES >= 2 && (LINES & (LINES - 1)) == 0)
         else $error("LINES must be a power of two");                    // R2
      AST_PARAM_WORDS: assert (WORDS >= 2 && (WORDS & (WORDS - 1)) == 0)
         else $error("WORDS must be a power of two");                    // R2
      AST_PARAM_WORD: assert (WORD_W >= 16 && (WORD_W & (WORD_W - 1)) == 0)
         else $error("WORD_W must be a power of two of at least 16");    // R2
      AST_PARAM_ADDR: assert (ADDR_W > OFF_W + $clog2(LINES))
         else $error("ADDR_W leaves no tag bits");                       // R2
   end

   AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |=> !cpu_ready);                                         // R9
   AST_NO_READY_IN_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !cpu_ready);                                           // R9
   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_write))); // R10
   AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_write && mem_ready) |=> (mem_req && !mem_write));  // R7
   AST_FILL_THEN_COMPARE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_write && mem_ready) |=> !mem_req);                // R4
   AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[OFF_W-1:0] == '0));                          // R2

endmodule

bind dm_wb_cache dm_wb_cache_chk #(
   .ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS), .LINES(LINES)
) i_chk (
   .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .mem_req(mem_req),
   .mem_write(mem_write), .mem_addr(mem_addr), .mem_ready(mem_ready)
);

// File: tb/test_dm_wb_cache.sv
`timescale 1ns/1ps
module test_dm_wb_cache;

   localparam int LAT       = 3;
   localparam int HIT_CYC   = 2;
   localparam int CLEAN_CYC = LAT + 4;
   localparam int DIRTY_CYC = 2 * LAT + 5;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cpu_valid = 1'b0;
   logic         cpu_write = 1'b0;
   logic [31:0]  cpu_addr = '0;
   logic [31:0]  cpu_wdata = '0;
   logic [31:0]  cpu_rdata;
   logic         cpu_ready;
   logic         mem_req;
   logic         mem_write;
   logic [31:0]  mem_addr;
   logic [127:0] mem_wdata;
   logic [127:0] mem_rdata = '0;
   logic         mem_ready = 1'b0;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dm_wb_cache i_dm_wb_cache (
      .clk(clk), .rst_n(rst_n),
      .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
      .mem_req(mem_req), .mem_write(mem_write), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
   );

   task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] seed_word(logic [31:0] a);
      return 32'hC0DE_0000 ^ {a[31:2], 2'b00};
   endfunction

   // ---------------- memory model ----------------
   logic [127:0] mem_lines [logic [27:0]];
   int           mem_wr_cnt = 0;
   int           mem_rd_cnt = 0;
   logic [31:0]  last_wr_addr = '0;
   logic [127:0] last_wr_data = '0;
   logic [31:0]  last_rd_addr = '0;
   logic [31:0]  held_addr = '0;
   int           hold_err = 0;
   int           cnt = 0;

   function automatic logic [127:0] line_of(logic [27:0] la);
      logic [127:0] l;
      if (mem_lines.exists(la)) return mem_lines[la];
      for (int w = 0; w < 4; w++) l[w*32 +: 32] = seed_word({la, w[1:0], 2'b00});
      return l;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ready <= 1'b0;
         cnt = 0;
      end else if (mem_ready) begin
         mem_ready <= 1'b0;
         cnt = 0;
      end else if (mem_req) begin
         if (cnt == 0) held_addr = mem_addr;
         else if (mem_addr !== held_addr) hold_err++;
         if (cnt == LAT - 1) begin
            mem_ready <= 1'b1;
            if (mem_write) begin
               mem_lines[mem_addr[31:4]] = mem_wdata;
               mem_wr_cnt++;
               last_wr_addr = mem_addr;
               last_wr_data = mem_wdata;
            end else begin
               mem_rdata <= line_of(mem_addr[31:4]);
               mem_rd_cnt++;
               last_rd_addr = mem_addr;
            end
         end else begin
            cnt++;
         end
      end
   end

   // ---------------- reference model and scoreboard ----------------
   logic [31:0] ref_words [logic [29:0]];
   logic [31:0] sb_data [$];
   bit          sb_read [$];
   string       sb_tag [$];

   function automatic logic [31:0] ref_rd(logic [31:0] a);
      if (ref_words.exists(a[31:2])) return ref_words[a[31:2]];
      return seed_word(a);
   endfunction

   always @(negedge clk) begin
      if (rst_n && cpu_ready) begin
         if (sb_data.size() == 0) begin
            n_checks++;
            n_errors++;
            $display("FAIL R9: unexpected ready actual 1 expected 0");
         end else begin
            logic [31:0] e;
            bit          r;
            string       t;
            e = sb_data.pop_front();
            r = sb_read.pop_front();
            t = sb_tag.pop_front();
            if (r) check32(t, cpu_rdata, e);
         end
      end
   end

   task automatic access(bit wr, logic [31:0] a, logic [31:0] d, int exp_cyc, string tag);
      int cyc = 0;
      sb_data.push_back(wr ? 32'h0 : ref_rd(a));
      sb_read.push_back(!wr);
      sb_tag.push_back({tag, " data"});
      if (wr) ref_words[a[31:2]] = d;
      cpu_write = wr;
      cpu_addr  = a;
      cpu_wdata = d;
      cpu_valid = 1'b1;
      do begin
         @(negedge clk);
         cyc++;
      end while (!cpu_ready && cyc < 200);
      cpu_valid = 1'b0;
      check32({tag, " latency"}, 32'(cyc), 32'(exp_cyc));
      @(negedge clk);
      check32("R9 ready pulse width", {31'b0, cpu_ready}, 32'h0);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual hung expected completion");
         finish_run();
      end
   end

   localparam logic [31:0] A = 32'h0000_1234;   // index 0x123, word 1
   localparam logic [31:0] B = 32'h0000_5234;   // same index, tag 1
   localparam logic [31:0] C = 32'h0008_0040;   // index 4, word 0
   localparam logic [31:0] D = 32'hFFFF_FFFC;   // index 0x3FF, word 3
   localparam logic [31:0] E = 32'h0000_3FFC;   // index 0x3FF, tag 0

   initial begin
      repeat (4) @(negedge clk);
      check32("R1 reset cpu_ready", {31'b0, cpu_ready}, 32'h0);
      check32("R1 reset mem_req", {31'b0, mem_req}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 / R4: cold read miss
      access(1'b0, A, '0, CLEAN_CYC, "R4 cold read miss");
      check32("R4 one memory read", 32'(mem_rd_cnt), 32'd1);
      check32("R4 no memory write", 32'(mem_wr_cnt), 32'd0);
      check32("R4 fetch address", last_rd_addr, 32'h0000_1230);

      // R3 / R2: hits on two words of the line
      access(1'b0, A, '0, HIT_CYC, "R3 read hit word1");
      access(1'b0, A + 32'd4, '0, HIT_CYC, "R2 read hit word2");

      // R6: write hit
      access(1'b1, A, 32'hDEAD_BEEF, HIT_CYC, "R6 write hit");
      access(1'b0, A, '0, HIT_CYC, "R6 read stored word");
      access(1'b0, A + 32'd4, '0, HIT_CYC, "R6 neighbour word untouched");
      check32("R6 no memory traffic", 32'(mem_wr_cnt + mem_rd_cnt), 32'd1);

      // R7: conflict miss on a modified line
      access(1'b0, B, '0, DIRTY_CYC, "R7 dirty conflict miss");
      check32("R7 one write-back", 32'(mem_wr_cnt), 32'd1);
      check32("R7 victim address", last_wr_addr, 32'h0000_1230);
      check32("R7 victim word1", last_wr_data[63:32], 32'hDEAD_BEEF);
      check32("R7 victim word0", last_wr_data[31:0], seed_word(32'h0000_1230));

      // R8: clean conflict miss, data comes back from memory
      access(1'b0, A, '0, CLEAN_CYC, "R8 clean conflict miss");
      check32("R8 no write-back", 32'(mem_wr_cnt), 32'd1);

      // R5: write allocate
      access(1'b1, C, 32'h1111_2222, CLEAN_CYC, "R5 write miss allocate");
      access(1'b0, C + 32'd8, '0, HIT_CYC, "R5 other word preserved");
      access(1'b0, C, '0, HIT_CYC, "R5 merged word");
      access(1'b0, C | 32'h0000_4000, '0, DIRTY_CYC, "R5 allocated line is modified");
      check32("R5 write-back count", 32'(mem_wr_cnt), 32'd2);
      check32("R5 written-back store", last_wr_data[31:0], 32'h1111_2222);

      // R2: top index and full tag position
      access(1'b1, D, 32'h7777_8888, CLEAN_CYC, "R2 top index write miss");
      access(1'b0, E, '0, DIRTY_CYC, "R2 top index conflict");
      check32("R2 victim tag position", last_wr_addr, 32'hFFFF_FFF0);
      check32("R2 word3 position", last_wr_data[127:96], 32'h7777_8888);
      access(1'b0, D, '0, DIRTY_CYC - LAT - 1, "R2 reread top index");

      // R1: reset over a modified line discards it
      access(1'b1, A, 32'hABCD_0123, HIT_CYC, "R1 dirty before reset");
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      ref_words[A[31:2]] = 32'hDEAD_BEEF;   // store lost with the cache contents
      access(1'b0, A, '0, CLEAN_CYC, "R1 miss after reset");
      check32("R1 no write-back after reset", 32'(mem_wr_cnt), 32'd3);

      check32("R10 request stable until ready", 32'(hold_err), 32'd0);
      check32("R9 scoreboard drained", 32'(sb_data.size()), 32'd0);

      done = 1'b1;
      finish_run();
   end

endmodule